// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a four-bank DDR SDRAM on every rising clock edge. It can act as a protocol monitor or as the front end of a behavioural memory model. Each cycle it turns the chip-select, row-strobe, column-strobe, write-enable and clock-enable levels into a one-hot command code. It keeps an open flag and the open row for every bank, and it holds the two mode registers. It also turns the data-mask pins into per-byte write enables, and it records protocol violations in sticky error bits.

All outputs are registered. Inputs sampled at clock edge k are reflected on the outputs right after edge k. The only exception is the delayed bank closure that an auto-precharge access schedules. That closure uses the burst length programmed in the mode register, counted in clocks, where one clock carries two data beats.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With `cs_n` low and `cke` high, the active-low `{ras_n,cas_n,we_n}` levels decode as 000 load-mode, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst-stop and 111 no-op. After the sampling edge, exactly one bit of `cmd_oh` is set: bit 0 no-op, 1 activate, 2 read, 3 write, 4 burst-stop, 5 precharge, 6 auto refresh, 7 self refresh, 8 load-mode.
- R2: With `cs_n` high, `cmd_oh` reports no-op and no bank, row or mode register changes, whatever the other pins carry. A scheduled auto-precharge closure still completes.
- R3: An activate to a closed bank opens bank `ba` with row `addr`. An activate to an open bank sets error bit 1 and leaves that bank's row unchanged.
- R4: A read or write addressed to a closed bank sets error bit 0.
- R5: A read or write to an open bank with `addr[10]` high closes that bank a fixed number of clocks after the sampling edge, equal to the programmed burst length in clocks. With `addr[10]` low the bank stays open.
- R6: A precharge with `addr[10]` low closes only bank `ba`. With `addr[10]` high it closes every bank and ignores `ba`.
- R7: The refresh encoding reports auto refresh (bit 6) when `cke` is high and self refresh (bit 7) when it is low. It changes no bank state. It sets error bit 2 if any bank is open.
- R8: A load-mode with `ba`=0 writes `addr` into `mode_reg`, and with `ba`=1 into `ext_mode_reg`. With `ba`=2 or 3, neither register changes.
- R9: The burst length used by R5 comes from `mode_reg[2:0]`: code 1 gives 1 clock, 2 gives 2 clocks and 3 gives 4 clocks. Any other code gives 1 clock.
- R10: A burst-stop that follows a read with `addr[10]` high, with no read or write in between, sets error bit 3. A burst-stop after a read with `addr[10]` low does not.
- R11: With `cke` low, any selected command other than refresh or no-op is reported as no-op, has no effect, and sets error bit 4.
- R12: `byte_wen` is the inverse of `dm` sampled at the same edge. A mask bit of 0 enables its byte.
- R13: A synchronous high `rst` makes `cmd_oh` report no-op and clears all bank open flags, both mode registers and all error bits. Error bits otherwise stay set once raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BANK_W | Bank address |
| addr | input | ADDR_W | Row, column or op-code bits |
| dm | input | NBYTES | Data mask, one bit per byte |
| cmd_oh | output | 9 | One-hot decoded command |
| bank_open | output | 2**BANK_W | Open flag per bank |
| open_rows | output | 2**BANK_W*ADDR_W | Open row per bank, bank 0 in the low bits |
| mode_reg | output | ADDR_W | Mode register |
| ext_mode_reg | output | ADDR_W | Extended mode register |
| err_flags | output | 5 | Sticky error bits |
| byte_wen | output | NBYTES | Per-byte write enable |

## Verification
The bench uses the default parameters: four banks, a 13-bit address and two data bytes. With a 13-bit address, bit 10 serves as the auto-precharge and precharge-all flag, and the bench can place full-width rows such as 0x1FFF. Two mask bits are enough to show that each byte enable follows its own mask bit. The bench reprograms the burst-length code between 1, 2 and 4 clocks, so the auto-precharge closure is seen at each delay. One of these closures overlaps a burst-stop.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

    localparam int CMD_W = 9;
    localparam int ERR_W = 5;
    localparam int AP_BIT = 10;
    localparam int CNT_W = 3;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_BST  = 4'd4,
        CMD_PRE  = 4'd5,
        CMD_AREF = 4'd6,
        CMD_SREF = 4'd7,
        CMD_LMR  = 4'd8
    } cmd_e;

    localparam int E_CLOSED = 0;
    localparam int E_REOPEN = 1;
    localparam int E_REFOPN = 2;
    localparam int E_BSTAP  = 3;
    localparam int E_CKE    = 4;

    // burst length code to clocks spent on the data bus
    function automatic logic [CNT_W-1:0] burst_clocks(input logic [2:0] code);
        case (code)
            3'd2:    return CNT_W'(2);
            3'd3:    return CNT_W'(4);
            default: return CNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    output cmd_e cmd,
    output logic cke_viol
);

    cmd_e raw;

    always_comb begin
        raw = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b000:  raw = CMD_LMR;
                3'b001:  raw = cke ? CMD_AREF : CMD_SREF;
                3'b010:  raw = CMD_PRE;
                3'b011:  raw = CMD_ACT;
                3'b100:  raw = CMD_WR;
                3'b101:  raw = CMD_RD;
                3'b110:  raw = CMD_BST;
                default: raw = CMD_NOP;
            endcase
        end
    end

    always_comb begin
        cmd      = raw;
        cke_viol = 1'b0;
        if (!cke && raw != CMD_AREF && raw != CMD_SREF && raw != CMD_NOP) begin
            cmd      = CMD_NOP;
            cke_viol = 1'b1;
        end
    end

endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot
    import ddr_cmd_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_i,
    input  logic             close_i,
    input  logic             ap_load_i,
    input  logic [CNT_W-1:0] ap_len_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);

    logic [CNT_W-1:0] ap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_o <= 1'b0;
            row_o  <= '0;
            ap_cnt <= '0;
        end else if (close_i) begin
            open_o <= 1'b0;
            ap_cnt <= '0;
        end else if (act_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
        end else if (ap_load_i) begin
            ap_cnt <= ap_len_i;
        end else if (ap_cnt != '0) begin
            if (ap_cnt == CNT_W'(1)) open_o <= 1'b0;
            ap_cnt <= ap_cnt - 1'b1;
        end
    end

    // R3
    act_opens_chk: assert property (@(posedge clk) disable iff (rst)
        act_i && !close_i |=> open_o && row_o == $past(row_i));

    // R6
    close_shuts_chk: assert property (@(posedge clk) disable iff (rst)
        close_i |=> !open_o);

    // R5
    pending_needs_open_chk: assert property (@(posedge clk) disable iff (rst)
        ap_cnt != '0 |-> open_o);

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
    import ddr_cmd_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13,
    parameter int NBYTES = 2,
    localparam int NB    = 1 << BANK_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 cke,
    input  logic [BANK_W-1:0]    ba,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NBYTES-1:0]    dm,
    output logic [CMD_W-1:0]     cmd_oh,
    output logic [NB-1:0]        bank_open,
    output logic [NB*ADDR_W-1:0] open_rows,
    output logic [ADDR_W-1:0]    mode_reg,
    output logic [ADDR_W-1:0]    ext_mode_reg,
    output logic [ERR_W-1:0]     err_flags,
    output logic [NBYTES-1:0]    byte_wen
);

    cmd_e             cmd;
    logic             cke_viol;
    logic             ap_req;
    logic             acc;
    logic             last_rd_ap;
    logic [CNT_W-1:0] ap_len;
    logic [ERR_W-1:0] err_new;

    ddr_cmd_decode u_dec (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .cke      (cke),
        .cmd      (cmd),
        .cke_viol (cke_viol)
    );

    assign ap_req = addr[AP_BIT];
    assign acc    = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign ap_len = burst_clocks(mode_reg[2:0]);

    for (genvar i = 0; i < NB; i++) begin : g_bank
        logic hit;
        assign hit = (ba == BANK_W'(i));
        ddr_bank_slot #(.ROW_W(ADDR_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .act_i     (cmd == CMD_ACT && hit && !bank_open[i]),
            .close_i   (cmd == CMD_PRE && (ap_req || hit)),
            .ap_load_i (acc && hit && bank_open[i] && ap_req),
            .ap_len_i  (ap_len),
            .row_i     (addr),
            .open_o    (bank_open[i]),
            .row_o     (open_rows[i*ADDR_W +: ADDR_W])
        );
    end

    always_comb begin
        err_new           = '0;
        err_new[E_CLOSED] = acc && !bank_open[ba];
        err_new[E_REOPEN] = (cmd == CMD_ACT) && bank_open[ba];
        err_new[E_REFOPN] = (cmd == CMD_AREF || cmd == CMD_SREF) && (|bank_open);
        err_new[E_BSTAP]  = (cmd == CMD_BST) && last_rd_ap;
        err_new[E_CKE]    = cke_viol;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_oh       <= CMD_W'(1);
            mode_reg     <= '0;
            ext_mode_reg <= '0;
            err_flags    <= '0;
            byte_wen     <= '0;
            last_rd_ap   <= 1'b0;
        end else begin
            cmd_oh    <= CMD_W'(1) << cmd;
            err_flags <= err_flags | err_new;
            byte_wen  <= ~dm;
            if (cmd == CMD_RD)      last_rd_ap <= ap_req;
            else if (cmd == CMD_WR) last_rd_ap <= 1'b0;
            if (cmd == CMD_LMR) begin
                if (ba == BANK_W'(0)) mode_reg     <= addr;
                if (ba == BANK_W'(1)) ext_mode_reg <= addr;
            end
        end
    end

    // R1
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $countones(cmd_oh) == 1);

    // R2
    desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> cmd_oh == CMD_W'(1) && $stable(mode_reg) && $stable(ext_mode_reg));

    // R6
    pre_all_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_n && cke && {ras_n, cas_n, we_n} == 3'b010 && addr[AP_BIT] |=> bank_open == '0);

    // R7
    ref_open_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_n && {ras_n, cas_n, we_n} == 3'b001 && (|bank_open) |=> err_flags[E_REFOPN]);

    // R11
    cke_low_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_n && !cke && {ras_n, cas_n, we_n} != 3'b001 && {ras_n, cas_n, we_n} != 3'b111
        |=> cmd_oh == CMD_W'(1) && err_flags[E_CKE]);

    // R13
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($past(err_flags) & ~err_flags) == '0);

endmodule

// File: tb/ddr_cmd_monitor_tb.sv
module ddr_cmd_monitor_tb;

    localparam logic [2:0] K_LMR = 3'b000, K_REF = 3'b001, K_PRE = 3'b010, K_ACT = 3'b011,
                           K_WR = 3'b100, K_RD = 3'b101, K_BST = 3'b110, K_NOP = 3'b111;
    localparam logic [8:0] O_NOP = 9'h001, O_ACT = 9'h002, O_RD = 9'h004, O_WR = 9'h008,
                           O_BST = 9'h010, O_PRE = 9'h020, O_AREF = 9'h040, O_SREF = 9'h080,
                           O_LMR = 9'h100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [1:0]  dm = '0;
    logic [8:0]  cmd_oh;
    logic [3:0]  bank_open;
    logic [51:0] open_rows;
    logic [12:0] mode_reg, ext_mode_reg;
    logic [4:0]  err_flags;
    logic [1:0]  byte_wen;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int         due;
        logic [8:0] cmd;
        logic [3:0] open;
        logic [4:0] err;
        logic [1:0] wen;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr_cmd_monitor u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .addr(addr), .dm(dm), .cmd_oh(cmd_oh), .bank_open(bank_open),
        .open_rows(open_rows), .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg),
        .err_flags(err_flags), .byte_wen(byte_wen)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each scoreboard entry once its sampling edge has passed
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " cmd"},  64'(cmd_oh),    64'(e.cmd));
            check({e.tag, " open"}, 64'(bank_open), 64'(e.open));
            check({e.tag, " err"},  64'(err_flags), 64'(e.err));
            check({e.tag, " wen"},  64'(byte_wen),  64'(e.wen));
        end
    end

    task automatic drive(input logic cs, input logic [2:0] k, input logic ck,
                         input logic [1:0] b, input logic [12:0] a, input logic [1:0] d,
                         input logic [8:0] ecmd, input logic [3:0] eopen,
                         input logic [4:0] eerr, input string tag);
        exp_t e;
        @(negedge clk);
        cs_n = cs; {ras_n, cas_n, we_n} = k; cke = ck; ba = b; addr = a; dm = d;
        e.due = cyc + 1; e.cmd = ecmd; e.open = eopen; e.err = eerr; e.wen = ~d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic cmd(input logic [2:0] k, input logic [1:0] b, input logic [12:0] a,
                       input logic [8:0] ecmd, input logic [3:0] eopen,
                       input logic [4:0] eerr, input string tag);
        drive(1'b0, k, 1'b1, b, a, 2'b00, ecmd, eopen, eerr, tag);
    endtask

    task automatic nop(input logic [3:0] eopen, input logic [4:0] eerr, input string tag);
        drive(1'b0, K_NOP, 1'b1, 2'd0, 13'd0, 2'b00, O_NOP, eopen, eerr, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        check("R13 rst cmd",  64'(cmd_oh),       64'(O_NOP));
        check("R13 rst open", 64'(bank_open),    64'(0));
        check("R13 rst err",  64'(err_flags),    64'(0));
        check("R13 rst mode", 64'(mode_reg),     64'(0));
        check("R13 rst emr",  64'(ext_mode_reg), 64'(0));
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        do_reset();
        // R8 mode registers, BL code 2
        cmd(K_LMR, 2'd0, 13'h0032, O_LMR, 4'b0000, 5'b00000, "R8 lmr mode");
        cmd(K_LMR, 2'd1, 13'h01A5, O_LMR, 4'b0000, 5'b00000, "R8 lmr ext");
        cmd(K_LMR, 2'd2, 13'h07FF, O_LMR, 4'b0000, 5'b00000, "R8 lmr ba2");
        // R3 activate
        cmd(K_ACT, 2'd1, 13'h0ABC, O_ACT, 4'b0010, 5'b00000, "R3 act b1");
        cmd(K_ACT, 2'd3, 13'h1FFF, O_ACT, 4'b1010, 5'b00000, "R3 act b3");
        // R2 deselect with load-mode pattern underneath
        drive(1'b1, K_LMR, 1'b1, 2'd0, 13'h0555, 2'b00, O_NOP, 4'b1010, 5'b00000, "R2 desel");
        nop(4'b1010, 5'b00000, "R1 nop");
        check("R8 mode",  64'(mode_reg),     64'(13'h0032));
        check("R8 ext",   64'(ext_mode_reg), 64'(13'h01A5));
        check("R3 row1",  64'(open_rows[13 +: 13]), 64'(13'h0ABC));
        check("R3 row3",  64'(open_rows[39 +: 13]), 64'(13'h1FFF));
        // R10 burst-stop after plain read is legal
        cmd(K_RD,  2'd1, 13'h0000, O_RD,  4'b1010, 5'b00000, "R1 rd");
        cmd(K_BST, 2'd0, 13'h0000, O_BST, 4'b1010, 5'b00000, "R10 bst ok");
        // R5/R12 write with auto precharge, 2 clocks
        drive(1'b0, K_WR, 1'b1, 2'd1, 13'h0400, 2'b01, O_WR, 4'b1010, 5'b00000, "R12 wr mask");
        nop(4'b1010, 5'b00000, "R5 ap wait");
        nop(4'b1000, 5'b00000, "R5 ap close");
        // R10 burst-stop after auto-precharge read
        cmd(K_RD,  2'd3, 13'h0400, O_RD,  4'b1000, 5'b00000, "R5 rd ap");
        cmd(K_BST, 2'd0, 13'h0000, O_BST, 4'b1000, 5'b01000, "R10 bst bad");
        nop(4'b0000, 5'b01000, "R5 rd ap close");
        // R4 access to closed bank
        cmd(K_RD,  2'd0, 13'h0000, O_RD,  4'b0000, 5'b01001, "R4 rd closed");
        cmd(K_ACT, 2'd0, 13'h0123, O_ACT, 4'b0001, 5'b01001, "R3 act b0");
        cmd(K_ACT, 2'd0, 13'h0456, O_ACT, 4'b0001, 5'b01011, "R3 reopen");
        nop(4'b0001, 5'b01011, "R3 nop");
        check("R3 row kept", 64'(open_rows[0 +: 13]), 64'(13'h0123));
        // R6 single precharge
        cmd(K_ACT, 2'd2, 13'h0005, O_ACT, 4'b0101, 5'b01011, "R3 act b2");
        cmd(K_PRE, 2'd0, 13'h0000, O_PRE, 4'b0100, 5'b01011, "R6 pre one");
        // R7 refresh with open bank
        cmd(K_REF, 2'd3, 13'h1FFF, O_AREF, 4'b0100, 5'b01111, "R7 aref open");
        // R6 precharge all, ba ignored
        cmd(K_PRE, 2'd1, 13'h0400, O_PRE, 4'b0000, 5'b01111, "R6 pre all");
        drive(1'b0, K_REF, 1'b0, 2'd0, 13'h0000, 2'b00, O_SREF, 4'b0000, 5'b01111, "R7 sref");
        // R11 cke low on activate
        drive(1'b0, K_ACT, 1'b0, 2'd1, 13'h0077, 2'b00, O_NOP, 4'b0000, 5'b11111, "R11 cke low");
        // R9 BL code 3 -> 4 clocks
        cmd(K_LMR, 2'd0, 13'h0003, O_LMR, 4'b0000, 5'b11111, "R9 lmr bl4");
        cmd(K_ACT, 2'd2, 13'h0007, O_ACT, 4'b0100, 5'b11111, "R9 act");
        cmd(K_RD,  2'd2, 13'h0400, O_RD,  4'b0100, 5'b11111, "R9 rd ap");
        nop(4'b0100, 5'b11111, "R9 wait1");
        nop(4'b0100, 5'b11111, "R9 wait2");
        nop(4'b0100, 5'b11111, "R9 wait3");
        nop(4'b0000, 5'b11111, "R9 close4");
        // R9 unlisted code -> 1 clock
        cmd(K_LMR, 2'd0, 13'h0006, O_LMR, 4'b0000, 5'b11111, "R9 lmr odd");
        cmd(K_ACT, 2'd0, 13'h0009, O_ACT, 4'b0001, 5'b11111, "R9 act b0");
        cmd(K_WR,  2'd0, 13'h0400, O_WR,  4'b0001, 5'b11111, "R9 wr ap");
        nop(4'b0000, 5'b11111, "R9 close1");
        @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R13 sticky", 64'(err_flags), 64'(5'b11111));
        check("R9 mode now", 64'(mode_reg), 64'(13'h0006));
        do_reset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule